// File: doc/BRIEF.md
# Flash Hardware Reset and Ready/Busy Sequencer

This block sits between the active-low hardware reset pin of a flash memory and the rest of the device. It passes the pin through a two-flop synchroniser and measures how long the pin stays low. A pulse that reaches the minimum width counts as a reset. A shorter pulse is discarded and leaves any program or erase in progress untouched.

For as long as a recognised reset is held, the block does four things. It asserts an abort that ends the embedded operation and returns the command state machine to read-array mode. It forces the data outputs to high impedance. It blocks all read and write commands. It drives the ready/busy output low for a recovery period. That period is long if the embedded-operation engine was busy when the reset was recognised and short if it was idle. An aborted operation is never resumed; the host must issue it again.

When the pin returns high, the abort, tristate and command-block signals drop. Reads stay forbidden for a further hold-off period. All widths and periods are parameters counted in clock cycles.

Top module: `flash_reset_seq`

## Requirements
- R1: The pin counts as a reset once its synchronised level has been low for MIN_PULSE consecutive cycles. If edge 0 is the first clock edge that samples the pin low, abortOp is 1 after edge MIN_PULSE+1.
- R2: A low pulse shorter than MIN_PULSE sampled cycles leaves every output unchanged. abortOp stays 0 and readyBusy keeps following engineBusy.
- R3: Once a reset is recognised, abortOp, outHiZ and cmdBlock are all 1 until release. All three return to 0 after the second clock edge that follows the first edge sampling the pin high.
- R4: If engineBusy is 1 at the recognition edge, readyBusy is 0 for exactly READY_LONG cycles starting with that edge, whatever engineBusy does afterwards.
- R5: If engineBusy is 0 at the recognition edge, readyBusy is 0 for exactly READY_SHORT cycles starting with that edge.
- R6: readAllowed is 0 while a reset is held. After the release edge, it stays 0 for exactly READ_HOLDOFF more cycles and then becomes 1.
- R7: After the block's own reset, abortOp, outHiZ and cmdBlock are 0 and readAllowed is 1. Outside a recovery period, readyBusy is the inverse of engineBusy (1 means ready).
- R8: A reset recognised while a ready recovery is still running restarts that recovery with the full period selected by engineBusy at the new recognition edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| sysRstN | input | 1 | Active-low reset of the block's own registers |
| resetPinN | input | 1 | Asynchronous active-low hardware reset pin |
| engineBusy | input | 1 | 1 while the embedded program/erase engine is running |
| abortOp | output | 1 | Terminates the embedded operation and holds the command state machine in read-array mode |
| outHiZ | output | 1 | Forces the data outputs to high impedance |
| cmdBlock | output | 1 | Discards read and write commands |
| readyBusy | output | 1 | 1 = ready, 0 = busy |
| readAllowed | output | 1 | 1 when array reads may be served |

## Verification
The bench drives pulses one cycle shorter than the minimum width and exactly at the minimum width. A design with an off-by-one in the qualification counter would abort on the short pulse or miss the exact one. It measures how long ready/busy stays low from the recognition edge, both with the engine busy and with it idle. A design that picked the wrong period, or let the engine's falling busy flag end the recovery early, would show the wrong count. It also re-asserts reset in the middle of a recovery and counts the read hold-off after release. Failing to restart the timer, or opening reads at the moment the pin rises, both show up as mismatches against the cycle model.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

  // Depth of the pin synchroniser.
  localparam int SYNC_STAGES = 2;

  // Load strobes from the control FSM into the datapath counters.
  typedef struct packed {
    logic loadLong;
    logic loadShort;
    logic loadHold;
  } rstStrobes_t;

  // Conditions reported by the datapath to the control FSM.
  typedef struct packed {
    logic pinLow;
    logic pinQual;
    logic rdyDone;
    logic holdDone;
  } rstStatus_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_rst_dp.sv
module flash_rst_dp
  import flash_rst_pkg::*;
#(
  parameter int MIN_PULSE    = 4,
  parameter int READY_LONG   = 40,
  parameter int READY_SHORT  = 10,
  parameter int READ_HOLDOFF = 6
) (
  input  logic        clk,
  input  logic        sysRstN,
  input  logic        resetPinN,
  input  rstStrobes_t strobes,
  output rstStatus_t  status
);

  localparam int QW = $clog2(MIN_PULSE + 1);
  localparam int RW = $clog2(maxOf(READY_LONG, READY_SHORT) + 1);
  localparam int HW = $clog2(READ_HOLDOFF + 1);
  localparam logic [QW-1:0] Q_SAT  = QW'(MIN_PULSE);
  localparam logic [QW-1:0] Q_HIT  = QW'(MIN_PULSE - 1);
  localparam logic [RW-1:0] R_LONG = RW'(READY_LONG);
  localparam logic [RW-1:0] R_SHRT = RW'(READY_SHORT);
  localparam logic [HW-1:0] H_LOAD = HW'(READ_HOLDOFF);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [QW-1:0]          lowCnt;
  logic [RW-1:0]          rdyCnt;
  logic [HW-1:0]          holdCnt;
  logic                   pinLow;

  // Synchroniser chain; idle level is high (not in reset).
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge sysRstN) begin
        if (!sysRstN) syncQ[g] <= 1'b1;
        else if (g == 0) syncQ[g] <= resetPinN;
        else syncQ[g] <= syncQ[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign pinLow = ~syncQ[SYNC_STAGES-1];

  // Pulse-width counter, saturating at the minimum width.
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)           lowCnt <= '0;
    else if (!pinLow)       lowCnt <= '0;
    else if (lowCnt != Q_SAT) lowCnt <= lowCnt + 1'b1;
  end

  // Ready/busy recovery timer.
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)              rdyCnt <= '0;
    else if (strobes.loadLong)  rdyCnt <= R_LONG;
    else if (strobes.loadShort) rdyCnt <= R_SHRT;
    else if (rdyCnt != '0)      rdyCnt <= rdyCnt - 1'b1;
  end

  // Read hold-off timer after release.
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)             holdCnt <= '0;
    else if (strobes.loadHold) holdCnt <= H_LOAD;
    else if (holdCnt != '0)    holdCnt <= holdCnt - 1'b1;
  end

  always_comb begin
    status.pinLow   = pinLow;
    status.pinQual  = pinLow && (lowCnt == Q_HIT);
    status.rdyDone  = (rdyCnt == '0);
    status.holdDone = (holdCnt == '0);
  end

endmodule

// File: rtl/flash_rst_ctl.sv
module flash_rst_ctl
  import flash_rst_pkg::*;
(
  input  logic        clk,
  input  logic        sysRstN,
  input  logic        engineBusy,
  input  rstStatus_t  status,
  output rstStrobes_t strobes,
  output logic        abortOp,
  output logic        outHiZ,
  output logic        cmdBlock,
  output logic        readyBusy,
  output logic        readAllowed
);

  logic held;
  logic recognise;
  logic release_;

  assign recognise = !held && status.pinQual;
  assign release_  = held && !status.pinLow;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)       held <= 1'b0;
    else if (recognise) held <= 1'b1;
    else if (release_)  held <= 1'b0;
  end

  always_comb begin
    strobes.loadLong  = recognise && engineBusy;
    strobes.loadShort = recognise && !engineBusy;
    strobes.loadHold  = release_;
  end

  assign abortOp     = held;
  assign outHiZ      = held;
  assign cmdBlock    = held;
  assign readyBusy   = status.rdyDone && !engineBusy;
  assign readAllowed = !held && status.holdDone;

endmodule

// File: rtl/flash_reset_seq.sv
module flash_reset_seq
  import flash_rst_pkg::*;
#(
  parameter int MIN_PULSE    = 4,
  parameter int READY_LONG   = 40,
  parameter int READY_SHORT  = 10,
  parameter int READ_HOLDOFF = 6
) (
  input  logic clk,
  input  logic sysRstN,
  input  logic resetPinN,
  input  logic engineBusy,
  output logic abortOp,
  output logic outHiZ,
  output logic cmdBlock,
  output logic readyBusy,
  output logic readAllowed
);

  rstStrobes_t strobes;
  rstStatus_t  status;

  flash_rst_dp #(
    .MIN_PULSE   (MIN_PULSE),
    .READY_LONG  (READY_LONG),
    .READY_SHORT (READY_SHORT),
    .READ_HOLDOFF(READ_HOLDOFF)
  ) u_dp (
    .clk      (clk),
    .sysRstN  (sysRstN),
    .resetPinN(resetPinN),
    .strobes  (strobes),
    .status   (status)
  );

  flash_rst_ctl u_ctl (
    .clk        (clk),
    .sysRstN    (sysRstN),
    .engineBusy (engineBusy),
    .status     (status),
    .strobes    (strobes),
    .abortOp    (abortOp),
    .outHiZ     (outHiZ),
    .cmdBlock   (cmdBlock),
    .readyBusy  (readyBusy),
    .readAllowed(readAllowed)
  );

endmodule

// File: rtl/flash_reset_seq_chk.sv
module flash_reset_seq_chk #(
  parameter int MIN_PULSE    = 4,
  parameter int READY_LONG   = 40,
  parameter int READY_SHORT  = 10,
  parameter int READ_HOLDOFF = 6
) (
  input logic clk,
  input logic sysRstN,
  input logic resetPinN,
  input logic engineBusy,
  input logic abortOp,
  input logic outHiZ,
  input logic cmdBlock,
  input logic readyBusy,
  input logic readAllowed
);

  // Consecutive low samples of the raw pin, saturating.
  int lowRun;
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)        lowRun <= 0;
    else if (resetPinN)  lowRun <= 0;
    else if (lowRun < MIN_PULSE + 4) lowRun <= lowRun + 1;
  end

  initial begin
    a_r6_holdoff_param: assert (READ_HOLDOFF >= 1 && READY_SHORT >= 1 && READY_LONG >= 1);
  end

  // R1/R2: an abort only starts after a qualifying pin pulse.
  a_r1_qualified_pulse: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(abortOp) |-> ($past(lowRun, 2) >= MIN_PULSE));

  // R4: busy engine at recognition -> ready/busy low.
  a_r4_busy_on_embedded: assert property (@(posedge clk) disable iff (!sysRstN)
    ($rose(abortOp) && $past(engineBusy)) |-> !readyBusy);

  // R5: idle engine at recognition -> ready/busy low too.
  a_r5_busy_on_idle: assert property (@(posedge clk) disable iff (!sysRstN)
    ($rose(abortOp) && !$past(engineBusy)) |-> !readyBusy);

  // R6: no reads while the reset is held.
  a_r6_no_read_held: assert property (@(posedge clk) disable iff (!sysRstN)
    abortOp |-> !readAllowed);

  // R6: reads still blocked right after release.
  a_r6_holdoff_after_release: assert property (@(posedge clk) disable iff (!sysRstN)
    $fell(abortOp) |-> !readAllowed);

  // R3: outputs tristated and commands blocked exactly while aborting.
  a_r3_hiz_and_block: assert property (@(posedge clk) disable iff (!sysRstN)
    abortOp |-> (outHiZ && cmdBlock));

endmodule

bind flash_reset_seq flash_reset_seq_chk #(
  .MIN_PULSE   (MIN_PULSE),
  .READY_LONG  (READY_LONG),
  .READY_SHORT (READY_SHORT),
  .READ_HOLDOFF(READ_HOLDOFF)
) u_chk (
  .clk        (clk),
  .sysRstN    (sysRstN),
  .resetPinN  (resetPinN),
  .engineBusy (engineBusy),
  .abortOp    (abortOp),
  .outHiZ     (outHiZ),
  .cmdBlock   (cmdBlock),
  .readyBusy  (readyBusy),
  .readAllowed(readAllowed)
);

// File: tb/tb_flash_reset_seq.sv
`timescale 1ns/1ps
module tb_flash_reset_seq;

  localparam int MP = 4;
  localparam int RL = 40;
  localparam int RS = 10;
  localparam int HO = 6;

  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic resetPinN = 1'b1;
  logic engineBusy = 1'b0;
  logic abortOp, outHiZ, cmdBlock, readyBusy, readAllowed;

  always #2.5 clk = ~clk;

  flash_reset_seq #(.MIN_PULSE(MP), .READY_LONG(RL), .READY_SHORT(RS), .READ_HOLDOFF(HO)) dut (
    .clk(clk), .sysRstN(sysRstN), .resetPinN(resetPinN), .engineBusy(engineBusy),
    .abortOp(abortOp), .outHiZ(outHiZ), .cmdBlock(cmdBlock),
    .readyBusy(readyBusy), .readAllowed(readAllowed));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: pin history queue plus timers as integers.
  logic pinHist[$];
  int   lowRun = 0;
  bit   mHeld = 0;
  int   mRdy = 0;
  int   mHold = 0;
  bit   modelOn = 0;

  always @(posedge clk) begin
    if (!sysRstN) begin
      pinHist = {1'b1, 1'b1};
      lowRun = 0; mHeld = 0; mRdy = 0; mHold = 0;
    end else begin
      cyc++;
      begin
        bit syncedLow;
        bit recog, rel;
        syncedLow = !pinHist[0];
        recog = !mHeld && syncedLow && (lowRun + 1 == MP);
        rel   = mHeld && !syncedLow;
        lowRun = syncedLow ? ((lowRun < MP) ? lowRun + 1 : MP) : 0;
        if (recog) mRdy = engineBusy ? RL : RS;
        else if (mRdy > 0) mRdy--;
        if (rel) mHold = HO;
        else if (mHold > 0) mHold--;
        if (recog) mHeld = 1; else if (rel) mHeld = 0;
        void'(pinHist.pop_front());
        pinHist.push_back(resetPinN);
      end
    end
  end

  // Per-cycle comparison and measurement monitors, away from the active edge.
  bit prevAbort = 0;
  bit prevAbortR = 0;
  bit cntRdy = 0, cntRd = 0;
  int rdyLow = 0, rdLow = 0;
  int rdyMeas = -1, rdMeas = -1;
  int abortRiseCyc = -1, abortFallCyc = -1;
  bit abortSeen = 0;

  always @(negedge clk) begin
    if (modelOn) begin
      check("R3", "abortOp", abortOp, mHeld);
      check("R3", "outHiZ", outHiZ, mHeld);
      check("R3", "cmdBlock", cmdBlock, mHeld);
      check("R4", "readyBusy", readyBusy, (mRdy == 0 && !engineBusy));
      check("R6", "readAllowed", readAllowed, (!mHeld && mHold == 0));
    end
    if (abortOp) abortSeen = 1;
    if (abortOp && !prevAbort) begin
      abortRiseCyc = cyc; cntRdy = 1; rdyLow = 0;
    end
    if (cntRdy) begin
      if (!readyBusy) rdyLow++;
      else begin cntRdy = 0; rdyMeas = rdyLow; end
    end
    if (!abortOp && prevAbort) begin
      abortFallCyc = cyc; cntRd = 1; rdLow = 0;
    end
    if (cntRd) begin
      if (!readAllowed) rdLow++;
      else begin cntRd = 0; rdMeas = rdLow; end
    end
    // The engine stops as soon as it is told to abort.
    if (abortOp) engineBusy <= 1'b0;
    prevAbort = abortOp;
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int lowCycles);
    resetPinN <= 1'b0;
    waitCycles(lowCycles);
    resetPinN <= 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int t0;
    waitCycles(3);
    sysRstN <= 1'b1;
    waitCycles(2);
    // R7: reset state
    check("R7", "abortOp after reset", abortOp, 0);
    check("R7", "outHiZ after reset", outHiZ, 0);
    check("R7", "readAllowed after reset", readAllowed, 1);
    check("R7", "readyBusy idle", readyBusy, 1);
    modelOn = 1;
    engineBusy <= 1'b1;
    waitCycles(2);
    check("R7", "readyBusy follows engine", readyBusy, 0);

    // R2: short pulse while busy is ignored
    abortSeen = 0;
    pulse(MP - 1);
    waitCycles(8);
    check("R2", "no abort on short pulse", abortSeen, 0);
    check("R2", "engine still busy seen", readyBusy, 0);
    engineBusy <= 1'b0;
    waitCycles(2);
    check("R2", "readyBusy after engine done", readyBusy, 1);

    // R1 + R5: exact minimum pulse with idle engine
    t0 = cyc;
    rdyMeas = -1; rdMeas = -1;
    pulse(MP);
    waitCycles(RS + HO + 10);
    check("R1", "recognition latency", abortRiseCyc - t0, MP + 2);
    check("R5", "short ready period", rdyMeas, RS);
    check("R6", "read holdoff after short pulse", rdMeas, HO);

    // R4 + R3 + R6: long held pulse with busy engine
    engineBusy <= 1'b1;
    waitCycles(3);
    rdyMeas = -1; rdMeas = -1;
    resetPinN <= 1'b0;
    waitCycles(20);
    check("R3", "held outputs", {abortOp, outHiZ, cmdBlock}, 3'b111);
    check("R6", "no reads while held", readAllowed, 0);
    resetPinN <= 1'b1;
    t0 = cyc;
    waitCycles(RL + HO);
    check("R3", "release latency", abortFallCyc - t0, 3);
    check("R4", "long ready period", rdyMeas, RL);
    check("R6", "read holdoff after long pulse", rdMeas, HO);

    // R8: second reset during a running recovery restarts it
    rdyMeas = -1;
    pulse(MP + 1);
    waitCycles(5);
    engineBusy <= 1'b1;
    pulse(MP + 2);
    waitCycles(RL + 10);
    check("R8", "recovery restarted with long period", rdyMeas, RL);
    engineBusy <= 1'b0;
    waitCycles(HO + 4);
    check("R7", "idle after all", {readyBusy, readAllowed}, 2'b11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule